// File: doc/BRIEF.md
# DVB-ASI Transmit Byte Pacer

The pacer sits between a transport-packet byte queue and an 8b/10b encoder on a serial video output. Every clock of the 27 MHz reference it emits one symbol: either a transport-stream byte or the K28.5 comma used as stuffing. A flag beside each symbol tells the encoder which kind it is. A 32-bit phase accumulator advances by a programmed increment each clock. Its carry-out is the transmit pulse, so the payload rate is the reference rate scaled by increment / 2^32.

Incoming bytes land in an internal queue that block RAM can hold. The queue counts how many complete packets it holds. At each packet boundary the framer takes a stored packet if one is complete. If none is complete, it sends a null packet, so the output rate never drops below the programmed value. Optionally, a 188-byte packet is stretched to 204 bytes by appending zeros. Payload slots can be spaced in two ways. In continuous spacing, one byte is sent per pulse. In burst spacing, pulses are saved up and then spent as a run of consecutive bytes.

Configuration inputs are expected to stay constant while the pacer runs. They are changed only under reset.

Top module: `asi_byte_pacer`

## Requirements
- R1: Payload slots occur exactly at the carries of a 32-bit accumulator that adds `rate_inc` every clock. Over any whole period of the accumulator, the number of payload bytes equals the number of carries. With `rate_inc` = 0, only commas are sent.
- R2: In continuous spacing (`burst_mode`=0), each transmit pulse releases exactly one payload byte. Payload bytes leave in packet order with no byte skipped or repeated.
- R3: Every symbol that is not payload is the comma: `out_sym`=0xBC with `out_is_k`=1. Every payload byte has `out_is_k`=0. After reset the output is a comma.
- R4: In continuous spacing with `rate_inc` = 2^32/N, consecutive payload bytes are exactly N clocks apart, including across packet boundaries.
- R5: In burst spacing (`burst_mode`=1), payload is sent in runs of exactly L consecutive clocks, separated by at least one comma. A run starts once L pulses have accumulated. L is `burst_len`, except that 0 is treated as 1 and a value above the output packet length is reduced to that length.
- R6: `src_len204`=1 selects 204-byte input packets; otherwise input packets are 188 bytes. The output packet length is the input length, or 204 when padding applies.
- R7: With `pad_en`=1 and 188-byte input, each packet is followed by 16 bytes of 0x00, giving 204 output bytes. With 204-byte input, `pad_en` has no effect.
- R8: When a packet boundary is reached and the queue holds no complete packet, a null packet is sent: 0x47, 0x1F, 0xFF, 0x10, then 0xFF up to the output packet length.
- R9: A packet that completes in the queue while a null packet is being sent waits for the null packet to finish. It then follows directly.
- R10: The queue accepts a byte when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` falls once FIFO_DEPTH bytes are held and none have been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock, one output symbol per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rate_inc | input | 32 | Phase increment per clock; payload rate = 27 MHz x rate_inc / 2^32 |
| burst_mode | input | 1 | 0 = continuous spacing, 1 = burst spacing |
| burst_len | input | 8 | Burst run length in bytes |
| src_len204 | input | 1 | 1 = 204-byte input packets, 0 = 188-byte |
| pad_en | input | 1 | Stretch 188-byte packets to 204 bytes with zeros |
| in_data | input | 8 | Transport-stream byte to queue |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Queue can accept a byte |
| out_sym | output | 8 | Symbol to the 8b/10b encoder |
| out_is_k | output | 1 | 1 = control symbol (K28.5), 0 = data byte |

## Verification
An accumulator carry registers a pulse one clock later. In continuous spacing, the payload byte for that pulse appears on `out_sym` on the following clock. In burst spacing, a run begins two clocks after the pulse that brings the saved count up to L.

The bench never assumes an absolute cycle for the first byte. It samples the outputs on the falling edge and records each payload byte together with the clock on which it appeared. It then checks byte content by position within the packet stream, gaps between successive bytes, run lengths of consecutive clocks, and payload counts over windows that are whole multiples of the accumulator period.

Inputs are driven on the falling edge as well. `in_ready` is read before each write, so the number of accepted bytes is known exactly.

// File: rtl/asi_pacer_pkg.sv
package asi_pacer_pkg;
  localparam logic [7:0] K28_5_CODE = 8'hBC;
  localparam logic [7:0] TS_SYNC    = 8'h47;
  localparam logic [7:0] NULL_PID_H = 8'h1F;
  localparam logic [7:0] NULL_PID_L = 8'hFF;
  localparam logic [7:0] NULL_FLAGS = 8'h10;
  localparam logic [7:0] NULL_FILL  = 8'hFF;
  localparam logic [7:0] PAD_BYTE   = 8'h00;
  localparam logic [7:0] LEN_SHORT  = 8'd188;
  localparam logic [7:0] LEN_LONG   = 8'd204;

  typedef enum logic {
    KIND_NULL = 1'b0,
    KIND_DATA = 1'b1
  } pkt_kind_t;
endpackage

// File: rtl/asi_rate_nco.sv
module asi_rate_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] rate_inc,
  output logic             pulse
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  always_comb sum = {1'b0, acc} + {1'b0, rate_inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else begin
      acc   <= sum[ACC_W-1:0];
      pulse <= sum[ACC_W];
    end
  end

  // R1
  nco_zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(rate_inc) != '0));
endmodule

// File: rtl/asi_pkt_fifo.sv
module asi_pkt_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src_len204,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          pop,
  input  logic          take_pkt,
  output logic [DW-1:0] rd_data,
  output logic          pkt_ready
);
  import asi_pacer_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_addr, rd_next;
  logic [LW-1:0] level, pkt_cnt;
  logic [7:0]    wr_pos, src_len;
  logic          push, pkt_done;

  always_comb begin
    src_len  = src_len204 ? LEN_LONG : LEN_SHORT;
    wr_ready = (level != LW'(DEPTH));
    push     = wr_valid && wr_ready;
    pkt_done = push && (wr_pos == src_len - 8'd1);
    rd_next  = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    rd_addr  = pop ? rd_next : rd_ptr;
    pkt_ready = (pkt_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      pkt_cnt <= '0;
      wr_pos  <= '0;
    end else begin
      if (push) begin
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
        wr_pos <= pkt_done ? 8'd0 : wr_pos + 8'd1;
      end
      if (pop) rd_ptr <= rd_next;
      level   <= level + LW'(push) - LW'(pop);
      pkt_cnt <= pkt_cnt + LW'(pkt_done) - LW'(take_pkt);
    end
  end

  // R8
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));

  // R9
  fifo_take_chk: assert property (@(posedge clk) disable iff (rst)
    take_pkt |-> pkt_ready);
endmodule

// File: rtl/asi_slot_spacer.sv
module asi_slot_spacer #(
  parameter int CRED_W = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pulse,
  input  logic       burst_mode,
  input  logic [7:0] burst_len,
  input  logic [7:0] out_len,
  output logic       send
);
  logic [CRED_W-1:0] credit, credit_nx;
  logic [7:0]        left, eff_len;
  logic              start, add_one;

  always_comb begin
    if (burst_len == 8'd0)      eff_len = 8'd1;
    else if (burst_len > out_len) eff_len = out_len;
    else                        eff_len = burst_len;

    send    = burst_mode ? (left != 8'd0) : pulse;
    start   = burst_mode && (left == 8'd0) && (credit >= CRED_W'(eff_len));
    add_one = pulse && (credit != '1);
    credit_nx = credit + CRED_W'(add_one) - CRED_W'(send);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit <= '0;
      left   <= '0;
    end else if (!burst_mode) begin
      credit <= '0;
      left   <= '0;
    end else begin
      credit <= credit_nx;
      if (start)     left <= eff_len;
      else if (send) left <= left - 8'd1;
    end
  end

  // R5
  burst_credit_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_mode && send) |-> (credit != '0));
endmodule

// File: rtl/asi_frame_builder.sv
module asi_frame_builder (
  input  logic       clk,
  input  logic       rst,
  input  logic       send,
  input  logic       src_len204,
  input  logic       pad_en,
  input  logic [7:0] fifo_byte,
  input  logic       pkt_ready,
  output logic       pop,
  output logic       take_pkt,
  output logic [7:0] out_len,
  output logic [7:0] out_sym,
  output logic       out_is_k
);
  import asi_pacer_pkg::*;

  logic [7:0] idx, src_len, sym;
  pkt_kind_t  cur_kind, kind;
  logic       at_start;

  always_comb begin
    src_len  = src_len204 ? LEN_LONG : LEN_SHORT;
    out_len  = (src_len204 || pad_en) ? LEN_LONG : LEN_SHORT;
    at_start = (idx == 8'd0);
    kind     = at_start ? (pkt_ready ? KIND_DATA : KIND_NULL) : cur_kind;
    take_pkt = send && at_start && pkt_ready;
    pop      = send && (kind == KIND_DATA) && (idx < src_len);
    if (kind == KIND_DATA) begin
      sym = (idx < src_len) ? fifo_byte : PAD_BYTE;
    end else begin
      case (idx)
        8'd0:    sym = TS_SYNC;
        8'd1:    sym = NULL_PID_H;
        8'd2:    sym = NULL_PID_L;
        8'd3:    sym = NULL_FLAGS;
        default: sym = NULL_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      cur_kind <= KIND_NULL;
      out_sym  <= K28_5_CODE;
      out_is_k <= 1'b1;
    end else begin
      if (send) begin
        idx      <= (idx == out_len - 8'd1) ? 8'd0 : idx + 8'd1;
        cur_kind <= kind;
      end
      out_sym  <= send ? sym : K28_5_CODE;
      out_is_k <= !send;
    end
  end

  // R3
  comma_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_is_k |-> (out_sym == K28_5_CODE));

  // R2
  slot_map_chk: assert property (@(posedge clk) disable iff (rst)
    out_is_k == !$past(send));
endmodule

// File: rtl/asi_byte_pacer.sv
module asi_byte_pacer #(
  parameter int ACC_W      = 32,
  parameter int FIFO_DEPTH = 512,
  parameter int CRED_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] rate_inc,
  input  logic             burst_mode,
  input  logic [7:0]       burst_len,
  input  logic             src_len204,
  input  logic             pad_en,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_sym,
  output logic             out_is_k
);
  logic       pulse, send, pop, take_pkt, pkt_ready;
  logic [7:0] fifo_byte, out_len;

  asi_rate_nco #(.ACC_W(ACC_W)) nco_i (
    .clk(clk), .rst(rst), .rate_inc(rate_inc), .pulse(pulse)
  );

  asi_slot_spacer #(.CRED_W(CRED_W)) spacer_i (
    .clk(clk), .rst(rst), .pulse(pulse), .burst_mode(burst_mode),
    .burst_len(burst_len), .out_len(out_len), .send(send)
  );

  asi_pkt_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) fifo_i (
    .clk(clk), .rst(rst), .src_len204(src_len204),
    .wr_data(in_data), .wr_valid(in_valid), .wr_ready(in_ready),
    .pop(pop), .take_pkt(take_pkt), .rd_data(fifo_byte), .pkt_ready(pkt_ready)
  );

  asi_frame_builder frame_i (
    .clk(clk), .rst(rst), .send(send), .src_len204(src_len204),
    .pad_en(pad_en), .fifo_byte(fifo_byte), .pkt_ready(pkt_ready),
    .pop(pop), .take_pkt(take_pkt), .out_len(out_len),
    .out_sym(out_sym), .out_is_k(out_is_k)
  );
endmodule

// File: tb/asi_byte_pacer_tb_top.sv
module asi_byte_pacer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;
  localparam int BUF_N      = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rate_inc = '0;
  logic        burst_mode = 1'b0;
  logic [7:0]  burst_len = 8'd8;
  logic        src_len204 = 1'b0;
  logic        pad_en = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_sym;
  logic        out_is_k;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit mon_en   = 1'b0;
  int cnt      = 0;
  logic [7:0] sym_buf [BUF_N];
  int         cyc_buf [BUF_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  asi_byte_pacer #(.ACC_W(32), .FIFO_DEPTH(DEPTH), .CRED_W(9)) dut_i (
    .clk(clk), .rst(rst), .rate_inc(rate_inc), .burst_mode(burst_mode),
    .burst_len(burst_len), .src_len204(src_len204), .pad_en(pad_en),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_sym(out_sym), .out_is_k(out_is_k)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_en && !out_is_k && cnt < BUF_N) begin
      sym_buf[cnt] = out_sym;
      cyc_buf[cnt] = cyc;
      cnt = cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return (k == 0) ? 8'h47 : 8'((k + seed) & 8'hFF);
  endfunction

  function automatic logic [7:0] null_byte(input int k);
    case (k)
      0: return 8'h47;
      1: return 8'h1F;
      2: return 8'hFF;
      3: return 8'h10;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic do_reset(input bit b204, input bit pad, input bit bm, input logic [7:0] bl);
    @(negedge clk);
    rst = 1'b1; rate_inc = '0; in_valid = 1'b0; mon_en = 1'b0; cnt = 0;
    src_len204 = b204; pad_en = pad; burst_mode = bm; burst_len = bl;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_pkt(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1;
      in_data  = pat(k, seed);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(input int n, input int max_cyc);
    cnt = 0;
    mon_en = 1'b1;
    for (int t = 0; t < max_cyc && cnt < n; t++) @(negedge clk);
    mon_en = 1'b0;
  endtask

  // R3: reset state
  task automatic t_reset();
    do_reset(1'b0, 1'b0, 1'b0, 8'd8);
    check(out_is_k == 1'b1 && out_sym == 8'hBC, "R3 reset comma", out_sym, 8'hBC);
    check(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
  endtask

  // R1: zero rate sends only commas
  task automatic t_zero_rate();
    int bad;
    do_reset(1'b0, 1'b0, 1'b0, 8'd8);
    push_pkt(188, 0);
    bad = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (!out_is_k || out_sym != 8'hBC) bad++;
    end
    check(bad == 0, "R1 zero rate only commas", bad, 0);
  endtask

  // R2 R4 R6 R8: continuous, 188, packet then null
  task automatic t_cont188();
    int bad_b, bad_g;
    do_reset(1'b0, 1'b0, 1'b0, 8'd8);
    push_pkt(188, 3);
    rate_inc = 32'h4000_0000;
    collect(376, 3000);
    check(cnt == 376, "R2 byte count", cnt, 376);
    bad_b = 0; bad_g = 0;
    for (int i = 0; i < 188; i++) if (sym_buf[i] != pat(i, 3)) bad_b++;
    check(bad_b == 0, "R2 R6 payload order", bad_b, 0);
    bad_b = 0;
    for (int i = 0; i < 188; i++) if (sym_buf[188+i] != null_byte(i)) bad_b++;
    check(bad_b == 0, "R8 null packet 188", bad_b, 0);
    for (int i = 1; i < 376; i++) if (cyc_buf[i] - cyc_buf[i-1] != 4) bad_g++;
    check(bad_g == 0, "R4 spacing of 4", bad_g, 0);
  endtask

  // R7: padding 188 -> 204
  task automatic t_pad();
    int bad_b, bad_g;
    do_reset(1'b0, 1'b1, 1'b0, 8'd8);
    push_pkt(188, 9);
    rate_inc = 32'h8000_0000;
    collect(408, 3000);
    bad_b = 0; bad_g = 0;
    for (int i = 0; i < 188; i++) if (sym_buf[i] != pat(i, 9)) bad_b++;
    for (int i = 188; i < 204; i++) if (sym_buf[i] != 8'h00) bad_b++;
    check(bad_b == 0, "R7 payload plus 16 zeros", bad_b, 0);
    bad_b = 0;
    for (int i = 0; i < 204; i++) if (sym_buf[204+i] != null_byte(i)) bad_b++;
    check(bad_b == 0, "R8 null packet 204", bad_b, 0);
    for (int i = 1; i < 408; i++) if (cyc_buf[i] - cyc_buf[i-1] != 2) bad_g++;
    check(bad_g == 0, "R4 spacing of 2", bad_g, 0);
  endtask

  // R6 R7: 204-byte input, pad_en ignored
  task automatic t_len204();
    int bad_b;
    do_reset(1'b1, 1'b1, 1'b0, 8'd8);
    push_pkt(204, 21);
    rate_inc = 32'h8000_0000;
    collect(206, 2000);
    bad_b = 0;
    for (int i = 0; i < 204; i++) if (sym_buf[i] != pat(i, 21)) bad_b++;
    check(bad_b == 0, "R6 204-byte payload", bad_b, 0);
    check(sym_buf[204] == 8'h47 && sym_buf[205] == 8'h1F, "R7 no pad on 204 input",
          {sym_buf[204], sym_buf[205]}, 16'h471F);
  endtask

  // R5: burst runs of 8
  task automatic t_burst8();
    int bad_r, run, bad_b;
    do_reset(1'b0, 1'b0, 1'b1, 8'd8);
    push_pkt(188, 5);
    rate_inc = 32'h4000_0000;
    collect(160, 3000);
    bad_r = 0; run = 1; bad_b = 0;
    for (int i = 1; i < 160; i++) begin
      if (cyc_buf[i] == cyc_buf[i-1] + 1) run++;
      else begin
        if (run != 8) bad_r++;
        run = 1;
      end
    end
    if (run != 8) bad_r++;
    check(bad_r == 0, "R5 burst run length 8", bad_r, 0);
    for (int i = 0; i < 160; i++) if (sym_buf[i] != pat(i, 5)) bad_b++;
    check(bad_b == 0, "R5 burst payload order", bad_b, 0);
  endtask

  // R5: burst_len 0 acts as 1
  task automatic t_burst0();
    int bad;
    do_reset(1'b0, 1'b0, 1'b1, 8'd0);
    rate_inc = 32'h4000_0000;
    collect(20, 400);
    bad = (cnt == 20) ? 0 : 1;
    for (int i = 1; i < cnt; i++) if (cyc_buf[i] - cyc_buf[i-1] != 4) bad++;
    check(bad == 0, "R5 burst_len 0 single bytes", bad, 0);
  endtask

  // R5: burst_len above packet length clamps to 188
  task automatic t_burst_clamp();
    int run;
    do_reset(1'b0, 1'b0, 1'b1, 8'd250);
    rate_inc = 32'h8000_0000;
    collect(189, 3000);
    run = 1;
    for (int i = 1; i < cnt; i++) begin
      if (cyc_buf[i] == cyc_buf[i-1] + 1) run++;
      else break;
    end
    check(cnt == 189 && run == 188, "R5 burst clamp 188", run, 188);
  endtask

  // R9: packet completes during a null packet
  task automatic t_mid_null();
    int bad_b;
    do_reset(1'b0, 1'b0, 1'b0, 8'd8);
    rate_inc = 32'h8000_0000;
    cnt = 0;
    mon_en = 1'b1;
    repeat (20) @(negedge clk);
    push_pkt(188, 40);
    for (int t = 0; t < 2000 && cnt < 376; t++) @(negedge clk);
    mon_en = 1'b0;
    bad_b = 0;
    for (int i = 0; i < 188; i++) if (sym_buf[i] != null_byte(i)) bad_b++;
    check(bad_b == 0, "R9 null packet not interrupted", bad_b, 0);
    bad_b = 0;
    for (int i = 0; i < 188; i++) if (sym_buf[188+i] != pat(i, 40)) bad_b++;
    check(bad_b == 0, "R9 waiting packet follows", bad_b, 0);
  endtask

  // R1: carries per accumulator period
  task automatic t_rate_count();
    do_reset(1'b0, 1'b0, 1'b0, 8'd8);
    rate_inc = 32'h6000_0000;
    repeat (16) @(negedge clk);
    cnt = 0;
    mon_en = 1'b1;
    repeat (800) @(negedge clk);
    mon_en = 1'b0;
    check(cnt == 300, "R1 300 bytes in 800 clocks", cnt, 300);
  endtask

  // R10: queue fills at DEPTH bytes
  task automatic t_full();
    int acc;
    do_reset(1'b0, 1'b0, 1'b0, 8'd8);
    acc = 0;
    for (int k = 0; k < DEPTH + 20; k++) begin
      if (!in_ready) break;
      in_valid = 1'b1;
      in_data  = 8'(k);
      @(negedge clk);
      acc++;
    end
    in_valid = 1'b0;
    check(acc == DEPTH, "R10 accepted bytes at full", acc, DEPTH);
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R10 ready stays low", in_ready, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_rate();
    t_cont188();
    t_pad();
    t_len204();
    t_burst8();
    t_burst0();
    t_burst_clamp();
    t_mid_null();
    t_rate_count();
    t_full();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule